// File: doc/BRIEF.md
# Misaligned Load/Store Unit

This unit sits between a simple processor core and a data memory that is organised in 32-bit words. The core hands it one request at a time: a byte address, an access size (byte, halfword or word), a sign-extension flag, a direction and, for stores, the value to write. The unit turns the request into one or two word-aligned memory cycles. Each cycle uses a strobe/acknowledge handshake and carries a byte-enable per lane. Any byte alignment is accepted. An access that runs past the end of a word is split: the first cycle covers the addressed word and the second covers the next word.

Lanes are little-endian. On a load, the unit collects the addressed bytes from one or both words and right-justifies them. It then widens the value to 32 bits with zeros or with copies of its top bit. On a store, it places the low bytes of the value in the addressed lanes and enables only those lanes, so neighbouring bytes are left untouched. The unit pulses `done` once the last acknowledge has been taken. A request with the unsupported 64-bit size code is refused with an `err` pulse and starts no memory cycle.

Top module: `unaligned_lsu`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_stb` are all 0.
- R2: Every memory cycle presents a word-aligned address (`mem_adr[1:0]` = 0). The first cycle targets the word holding the start address, and a second cycle targets that word plus 4, wrapping within 21 bits.
- R3: Size code 00 requests 1 byte, 01 requests 2 bytes and 10 requests 4 bytes. The request mask is 0001, 0011 or 1111 and is shifted left by the address offset (`addr[1:0]`). Bits 3:0 of the shifted mask are the first cycle's `mem_sel`, and bits 7:4 are the second cycle's `mem_sel`.
- R4: Exactly two cycles are issued when offset plus byte count exceeds 4, and exactly one otherwise.
- R5: A store writes byte k of the value (bits 8k+7:8k) to address+k for each k below the byte count. No other memory byte changes, whatever the higher bits of the value hold.
- R6: A load returns the byte at address+k in bits 8k+7:8k of `rdata`, for each k below the byte count.
- R7: On a byte or halfword load, bits above the loaded width are copies of bit 7 (byte) or bit 15 (halfword) when `req_sext` is 1, and zero when it is 0.
- R8: `done` is high for exactly one cycle, the cycle after the final acknowledge is taken; `rdata` holds the load result from that cycle on.
- R9: While `mem_stb` is high and `mem_ack` is low, `mem_stb`, `mem_adr`, `mem_sel`, `mem_wdat` and `mem_we` keep their values in the next cycle.
- R10: A request with size code 11 raises `err` for one cycle in the next cycle, issues no memory cycle and raises no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `busy` is 0 |
| req_we | input | 1 | 1 for store, 0 for load |
| req_addr | input | 21 | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 unsupported |
| req_sext | input | 1 | Sign-extend a load result |
| req_wdata | input | 32 | Store value, right-justified |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse at completion |
| err | output | 1 | One-cycle pulse for a refused request |
| rdata | output | 32 | Extended load result |
| mem_stb | output | 1 | Memory cycle strobe |
| mem_we | output | 1 | Memory write enable |
| mem_adr | output | 21 | Word-aligned memory address |
| mem_sel | output | 4 | Byte lane enables |
| mem_wdat | output | 32 | Lane-aligned write data |
| mem_rdat | input | 32 | Memory read data |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
If the captured offset or size is wrong, the fault shows in the very first cycle as a wrong `mem_sel` or a wrong count of cycles. A stuck state register shows up as a second cycle that never comes, or one that should not appear. Errors in the gather or widen path show only at `done`, as wrong bytes or a wrong fill above the loaded width. Errors in the lane placement of a store show only when the memory contents are compared afterwards. For that reason, every store is followed by a comparison of the whole memory model, and every load result is checked on the `done` cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } lsu_state_e;
endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/lsu_lane_plan.sv
module lsu_lane_plan #(
  parameter int DATA_W = 32
) (
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [1:0]                  size,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W/8-1:0]         sel_lo,
  output logic [DATA_W/8-1:0]         sel_hi,
  output logic [DATA_W-1:0]           dat_lo,
  output logic [DATA_W-1:0]           dat_hi,
  output logic                        split
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [LANES-1:0]    keep;
  logic [DATA_W-1:0]   wclean;
  logic [2*LANES-1:0]  wide_sel;
  logic [2*DATA_W-1:0] wide_dat;
  logic [OFF_W+2:0]    bit_shift;

  // one enable and one cleaned byte per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign keep[g]            = (g < (1 << size));
    assign wclean[8*g +: 8]   = keep[g] ? wdata[8*g +: 8] : 8'h00;
  end

  assign bit_shift = {off, 3'b000};
  assign wide_sel  = {{LANES{1'b0}}, keep} << off;
  assign wide_dat  = {{DATA_W{1'b0}}, wclean} << bit_shift;

  assign sel_lo = wide_sel[LANES-1:0];
  assign sel_hi = wide_sel[2*LANES-1:LANES];
  assign dat_lo = wide_dat[DATA_W-1:0];
  assign dat_hi = wide_dat[2*DATA_W-1:DATA_W];
  assign split  = |sel_hi;
endmodule

// File: rtl/lsu_load_gather.sv
module lsu_load_gather #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]           lo_word,
  input  logic [DATA_W-1:0]           hi_word,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [1:0]                  size,
  input  logic                        sext,
  output logic [DATA_W-1:0]           result
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [2*DATA_W-1:0] pair;
  logic [DATA_W-1:0]   just;
  logic [LANES-1:0]    keep;
  logic [OFF_W+2:0]    bit_shift;
  logic                fill;

  assign bit_shift = {off, 3'b000};
  assign pair      = {hi_word, lo_word} >> bit_shift;
  assign just      = pair[DATA_W-1:0];

  always_comb begin
    fill = 1'b0;
    if (sext) begin
      unique case (size)
        2'b00:   fill = just[7];
        2'b01:   fill = just[15];
        default: fill = 1'b0;
      endcase
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign keep[g]              = (g < (1 << size));
    assign result[8*g +: 8]     = keep[g] ? just[8*g +: 8] : {8{fill}};
  end
endmodule

// File: rtl/unaligned_lsu.sv
module unaligned_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_sext,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              mem_stb,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_adr,
  output logic [DATA_W/8-1:0] mem_sel,
  output logic [DATA_W-1:0] mem_wdat,
  input  logic [DATA_W-1:0] mem_rdat,
  input  logic              mem_ack
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic rst_sn;
  lsu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  lsu_state_e        st_q, st_d;
  logic [ADDR_W-1:0] word_adr_q;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              sext_q, we_q;
  logic [DATA_W-1:0] wdata_q, lo_q, rdata_q;
  logic              done_q, err_q;

  logic              done_d, err_d, cap_en, lo_en, rd_en;
  logic [ADDR_W-1:0] next_adr;
  logic [LANES-1:0]  sel_lo, sel_hi;
  logic [DATA_W-1:0] dat_lo, dat_hi, g_lo, g_hi, g_res;
  logic              split;

  lsu_lane_plan #(.DATA_W(DATA_W)) u_plan (
    .off(off_q), .size(size_q), .wdata(wdata_q),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .dat_lo(dat_lo), .dat_hi(dat_hi),
    .split(split)
  );

  assign g_lo = (st_q == ST_SECOND) ? lo_q : mem_rdat;
  assign g_hi = (st_q == ST_SECOND) ? mem_rdat : '0;

  lsu_load_gather #(.DATA_W(DATA_W)) u_gather (
    .lo_word(g_lo), .hi_word(g_hi), .off(off_q), .size(size_q),
    .sext(sext_q), .result(g_res)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    cap_en = 1'b0;
    lo_en  = 1'b0;
    rd_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_size == SZ_BAD) begin
            err_d = 1'b1;
          end else begin
            cap_en = 1'b1;
            st_d   = ST_FIRST;
          end
        end
      end
      ST_FIRST: begin
        if (mem_ack) begin
          if (split) begin
            lo_en = 1'b1;
            st_d  = ST_SECOND;
          end else begin
            st_d   = ST_IDLE;
            done_d = 1'b1;
            rd_en  = !we_q;
          end
        end
      end
      ST_SECOND: begin
        if (mem_ack) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          rd_en  = !we_q;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  // request capture, enabled on acceptance
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_adr_q <= '0;
      off_q      <= '0;
      size_q     <= 2'b00;
      sext_q     <= 1'b0;
      we_q       <= 1'b0;
      wdata_q    <= '0;
    end else if (cap_en) begin
      word_adr_q <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
      off_q      <= req_addr[OFF_W-1:0];
      size_q     <= req_size;
      sext_q     <= req_sext;
      we_q       <= req_we;
      wdata_q    <= req_wdata;
    end
  end

  // first-word hold for split loads
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdat;
  end

  // load result
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)    rdata_q <= '0;
    else if (rd_en) rdata_q <= g_res;
  end

  assign next_adr = word_adr_q + ADDR_W'(LANES);

  always_comb begin
    mem_adr  = '0;
    mem_sel  = '0;
    mem_wdat = '0;
    unique case (st_q)
      ST_FIRST: begin
        mem_adr  = word_adr_q;
        mem_sel  = sel_lo;
        mem_wdat = dat_lo;
      end
      ST_SECOND: begin
        mem_adr  = next_adr;
        mem_sel  = sel_hi;
        mem_wdat = dat_hi;
      end
      default: ;
    endcase
  end

  assign mem_stb = (st_q != ST_IDLE);
  assign mem_we  = mem_stb & we_q;
  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign err     = err_q;
  assign rdata   = rdata_q;
endmodule

// File: rtl/lsu_chk.sv
module lsu_chk #(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                done,
  input logic                err,
  input logic                mem_stb,
  input logic                mem_we,
  input logic                mem_ack,
  input logic [ADDR_W-1:0]   mem_adr,
  input logic [DATA_W/8-1:0] mem_sel,
  input logic [DATA_W-1:0]   mem_wdat
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  // R2
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb |-> (mem_adr[OFF_W-1:0] == '0));

  // R2
  next_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_stb && mem_ack) && mem_stb) |->
      (mem_adr == $past(mem_adr) + ADDR_W'(LANES)));

  // R3
  lanes_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_stb |-> (mem_sel != '0));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(mem_stb && mem_ack));

  // R9
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_stb && !mem_ack) |=> (mem_stb && $stable(mem_adr) && $stable(mem_sel)
                               && $stable(mem_wdat) && $stable(mem_we)));

  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!mem_stb && !done));
endmodule

bind unaligned_lsu lsu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_sn), .done(done), .err(err), .mem_stb(mem_stb),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_adr(mem_adr), .mem_sel(mem_sel),
  .mem_wdat(mem_wdat)
);

// File: tb/tb_unaligned_lsu.sv
module tb_unaligned_lsu;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 21;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_we, req_sext;
  logic [AW-1:0] req_addr;
  logic [1:0]    req_size;
  logic [DW-1:0] req_wdata;
  logic          busy, done, err, mem_stb, mem_we, mem_ack;
  logic [AW-1:0] mem_adr;
  logic [3:0]    mem_sel;
  logic [DW-1:0] mem_wdat, mem_rdat;

  unaligned_lsu #(.ADDR_W(AW), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_sext(req_sext),
    .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
    .rdata(rdata), .mem_stb(mem_stb), .mem_we(mem_we), .mem_adr(mem_adr),
    .mem_sel(mem_sel), .mem_wdat(mem_wdat), .mem_rdat(mem_rdat),
    .mem_ack(mem_ack)
  );
  logic [DW-1:0] rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad   = 0;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 53 + 29) ^ (i << 3));
  endfunction

  // memory model: 64 bytes, aliased over the address space
  logic [7:0] mem_b [64];
  logic [7:0] shadow [64];
  int lat = 0;
  int cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      cnt     <= 0;
      for (int i = 0; i < 64; i++) mem_b[i] <= pat(i);
    end else if (mem_stb && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        cnt     <= 0;
        if (mem_we)
          for (int j = 0; j < 4; j++)
            if (mem_sel[j]) mem_b[{mem_adr[5:2], 2'(j)}] <= mem_wdat[8*j +: 8];
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  assign mem_rdat = {mem_b[{mem_adr[5:2], 2'd3}], mem_b[{mem_adr[5:2], 2'd2}],
                     mem_b[{mem_adr[5:2], 2'd1}], mem_b[{mem_adr[5:2], 2'd0}]};

  // monitor, sampled at the falling edge
  int            ncyc = 0;
  int            ack_total = 0;
  int            last_ack_cyc = -10;
  int            hold_bad = 0;
  logic [3:0]    sel_prev, sel_last;
  logic [AW-1:0] adr_prev, adr_last;
  logic          p_stb = 1'b0, p_ack = 1'b0, p_we = 1'b0;
  logic [AW-1:0] p_adr = '0;
  logic [3:0]    p_sel = '0;
  logic [DW-1:0] p_wdat = '0;

  always @(negedge clk) begin
    ncyc <= ncyc + 1;
    if (p_stb && !p_ack) begin
      if (!mem_stb || mem_adr != p_adr || mem_sel != p_sel ||
          mem_wdat != p_wdat || mem_we != p_we)
        hold_bad <= hold_bad + 1;
    end
    p_stb <= mem_stb; p_ack <= mem_ack; p_adr <= mem_adr;
    p_sel <= mem_sel; p_wdat <= mem_wdat; p_we <= mem_we;
    if (mem_stb && mem_ack) begin
      ack_total    <= ack_total + 1;
      last_ack_cyc <= ncyc;
      sel_prev     <= sel_last;
      adr_prev     <= adr_last;
      sel_last     <= mem_sel;
      adr_last     <= mem_adr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; checks R2 R3 R4 R5/R6/R7 R8
  task automatic run(input bit we, input logic [AW-1:0] addr, input int size,
                     input bit sext, input logic [DW-1:0] wdata, input int l);
    int start, beats, n, k, exp_beats, mism;
    logic [7:0]    wsel;
    logic [DW-1:0] exp_val;
    logic [AW-1:0] wadr;
    @(negedge clk);
    lat       = l;
    start     = ack_total;
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = addr;
    req_size  = 2'(size);
    req_sext  = sext;
    req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    req_wdata = 32'hDEAD_BEEF;
    k = 0;
    while (!done && !err && k < 200) begin
      @(negedge clk);
      k++;
    end
    beats = ack_total - start;
    if (size == 3) begin
      chk(err == 1'b1, "R10 err pulse", 64'(err), 64'd1);
      chk(beats == 0 && done == 1'b0, "R10 no cycle", 64'(beats), 64'd0);
      @(negedge clk);
      chk(err == 1'b0 && ack_total == start, "R10 err single", 64'(err), 64'd0);
      mism = 0;
      for (int i = 0; i < 64; i++) if (mem_b[i] != shadow[i]) mism++;
      chk(mism == 0, "R10 memory untouched", 64'(mism), 64'd0);
      return;
    end
    chk(done == 1'b1, "R8 done seen", 64'(done), 64'd1);
    chk(ncyc == last_ack_cyc + 1, "R8 done one cycle after last ack",
        64'(ncyc - last_ack_cyc), 64'd1);
    n         = 1 << size;
    wsel      = 8'(((1 << n) - 1) << addr[1:0]);
    exp_beats = (wsel[7:4] != 4'h0) ? 2 : 1;
    wadr      = {addr[AW-1:2], 2'b00};
    chk(beats == exp_beats, "R4 cycle count", 64'(beats), 64'(exp_beats));
    if (beats == 2) begin
      chk(sel_prev == wsel[3:0] && sel_last == wsel[7:4], "R3 lane enables",
          {56'd0, sel_prev, sel_last}, {56'd0, wsel});
      chk(adr_prev == wadr && adr_last == wadr + AW'(4), "R2 cycle addresses",
          {21'd0, adr_prev, adr_last}, {21'd0, wadr, wadr + AW'(4)});
    end else begin
      chk(sel_last == wsel[3:0], "R3 lane enables", 64'(sel_last), 64'(wsel));
      chk(adr_last == wadr, "R2 cycle address", 64'(adr_last), 64'(wadr));
    end
    if (we) begin
      for (int i = 0; i < n; i++) shadow[6'(int'(addr[5:0]) + i)] = wdata[8*i +: 8];
      mism = 0;
      for (int i = 0; i < 64; i++) if (mem_b[i] != shadow[i]) mism++;
      chk(mism == 0, "R5 memory after store", 64'(mism), 64'd0);
    end else begin
      exp_val = '0;
      for (int i = 0; i < n; i++)
        exp_val[8*i +: 8] = shadow[6'(int'(addr[5:0]) + i)];
      if (sext && n < 4 && exp_val[8*n-1])
        for (int b = 8*n; b < 32; b++) exp_val[b] = 1'b1;
      chk(rdata == exp_val, sext ? "R7 R6 load sign-extended" : "R7 R6 load zero-extended",
          64'(rdata), 64'(exp_val));
    end
    @(negedge clk);
    chk(done == 1'b0, "R8 done lasts one cycle", 64'(done), 64'd0);
    if (!we) chk(rdata == exp_val, "R8 rdata held", 64'(rdata), 64'(exp_val));
  endtask

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int idx;
    for (int i = 0; i < 64; i++) shadow[i] = pat(i);
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_size = 2'b00;
    req_sext = 1'b0; req_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0 && mem_stb == 1'b0,
        "R1 reset outputs", {60'd0, busy, done, err, mem_stb}, 64'd0);

    idx = 0;
    // loads before any store, all sizes, offsets and fills
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++)
        for (int x = 0; x < 2; x++) begin
          run(1'b0, AW'(32'h300 + 8 * s + o), s, x[0], '0, idx % 3);
          idx++;
        end
    // stores with garbage above the stored width
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++) begin
        run(1'b1, AW'(32'h210 + 8 * s + o), s, 1'b0,
            32'h9A5C_0000 | 32'(((s * 4 + o) * 97 + 129) & 32'hFFFF) | 32'h0000_8080, idx % 3);
        idx++;
      end
    // read back the stored region
    for (int s = 0; s < 3; s++)
      for (int o = 0; o < 4; o++)
        for (int x = 0; x < 2; x++) begin
          run(1'b0, AW'(32'h210 + 8 * s + o), s, x[0], '0, (idx + x) % 4);
          idx++;
        end
    // split across the top of the address space: R2 wrap
    run(1'b1, AW'(32'h1F_FFFE), 2, 1'b0, 32'h44AF_BECD, 1);
    run(1'b0, AW'(32'h1F_FFFD), 2, 1'b0, '0, 0);
    run(1'b0, AW'(32'h1F_FFFF), 1, 1'b1, '0, 2);
    // refused size code
    run(1'b1, AW'(32'h205), 3, 1'b0, 32'hFFFF_FFFF, 0);
    run(1'b0, AW'(32'h207), 3, 1'b1, '0, 0);
    // R9 handshake hold across every wait cycle
    chk(hold_bad == 0, "R9 outputs held while waiting", 64'(hold_bad), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule